// File: doc/BRIEF.md
# Single-Wire Gauge Bus Master

This block drives a single-wire, half-duplex serial bus of the kind used to talk to battery fuel gauges. Software reaches it through a simple synchronous register port. Three operations are available: a break pulse, which resets the slave; a byte write, where the master shifts out the byte; and a byte read, where the slave shifts a byte back. On the wire the master has an open-drain pull-down enable. It receives the bus level through a two-flop synchroniser.

The three operations are chosen by the initialise, direction and go bits of the control register. Go starts an operation, and the hardware clears it when the operation finishes. A completed write sets a transmit-complete flag and a completed read sets a receive-complete flag. A finished break sets the timeout flag, and so does a slave that stays silent during a read. All three flags clear when the flag register is read. A level interrupt follows the flags when interrupts are enabled.

Every bit timing is a parameter counted in clock cycles. These are the break low time, the break recovery time, the bit cell length, the low times for a one and for a zero, and the slave response window. Data moves least significant bit first. A soft reset returns the block to its reset state and shows its progress through a reset-done bit.

Top module: `swire_master`

## Requirements
- R1: Registers sit at byte offsets 0x00 revision, 0x04 transmit data, 0x08 receive data, 0x0C control, 0x10 flags, 0x14 configuration and 0x18 status. A read returns its value on `reg_rdata` one cycle after the request. The revision reads {REV_MAJOR, REV_MINOR}, one nibble each with the major nibble on top, and any other offset reads 0x00.
- R2: Control bit positions are 0 mode, 1 direction (1 = read), 2 initialise, 4 go, 5 clock enable and 6 interrupt enable. All six read back as written, and bits 3 and 7 read 0.
- R3: Writing the control register with go=1, initialise=0 and direction=0 while idle sends the transmit byte LSB first. Each bit takes CELL cycles: the line is driven low for LOW1 cycles for a 1 and LOW0 cycles for a 0, then released. At the end flag bit 2 (transmit complete) is set.
- R4: Go=1, direction=1 and initialise=0 starts a read. For each bit the master waits for a falling edge from the slave and samples the synchronised line CELL/2 cycles later: high gives 1 and low gives 0. The 8 bits are assembled LSB first into receive data, and flag bit 1 (receive complete) is set.
- R5: If no falling edge arrives within RESP_WIN cycles during a read, the read stops, flag bit 0 (timeout) is set, go clears and receive data keeps its old value.
- R6: Go=1 with initialise=1 issues a break: the line is low for BRK_LOW cycles, then released for BRK_REC cycles. Flag bit 0 is then set, and initialise and go clear.
- R7: A read of the flag register returns the three flags and clears them all.
- R8: `irq` is high exactly when interrupt enable is 1 and at least one flag is set.
- R9: When interrupt enable is 0, go and initialise stay 1 after an operation finishes. The flag is still set, and no further operation starts by itself.
- R10: A control write made while an operation is in progress is ignored, and the running operation completes normally.
- R11: Writing configuration bit 1 as 1 is a soft reset. It aborts any operation, releases the line, and clears control, flags, both data registers and the configuration. Status bit 0 then reads 0 for RST_CYCLES cycles and 1 afterwards. Configuration bit 1 reads 0.
- R12: Configuration bit 0 (auto-idle) is stored and reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after a read request |
| irq | output | 1 | Level interrupt |
| line_oe | output | 1 | 1 = pull the bus wire low |
| line_in | input | 1 | Bus wire level as seen at the pad |

## Verification
The assertions assume the register port only starts an operation through a control write while the engine is idle. They also assume the bus wire rests high whenever neither side pulls it. The bench keeps to both assumptions. It models the wire as a wired-AND of the master pull-down and a slave model. It starts each new operation only after the previous one has had time to finish. The slave model answers each read with cells whose low times fall clearly on either side of the mid-cell sample point, so the synchroniser delay cannot move a decision.

// File: rtl/swire_pkg.sv
package swire_pkg;

    localparam int unsigned OFF_REV = 'h00;
    localparam int unsigned OFF_TXD = 'h04;
    localparam int unsigned OFF_RXD = 'h08;
    localparam int unsigned OFF_CTL = 'h0C;
    localparam int unsigned OFF_FLG = 'h10;
    localparam int unsigned OFF_CFG = 'h14;
    localparam int unsigned OFF_STS = 'h18;

    // control bit positions
    localparam int unsigned CB_DIR  = 1;
    localparam int unsigned CB_INIT = 2;
    localparam int unsigned CB_GO   = 4;
    localparam int unsigned CB_IE   = 6;
    localparam logic [7:0]  CTL_MASK = 8'h77;

    // configuration bit positions
    localparam int unsigned CFG_IDLE = 0;
    localparam int unsigned CFG_SRST = 1;

    typedef enum logic [1:0] {
        OP_TX  = 2'd0,
        OP_RX  = 2'd1,
        OP_BRK = 2'd2
    } op_e;

    typedef struct packed {
        logic tx;
        logic rx;
        logic brk;
        logic silent;
    } done_t;

endpackage

// File: rtl/swire_sync.sv
module swire_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= 1'b1;
                else        chain_q <= d_in;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], d_in};
            end
        end
    endgenerate

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/swire_engine.sv
module swire_engine
    import swire_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int BRK_LOW  = 40,
    parameter int BRK_REC  = 20,
    parameter int CELL     = 30,
    parameter int LOW1     = 6,
    parameter int LOW0     = 22,
    parameter int RESP_WIN = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  op_e               op,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              abort,
    input  logic              line_s,
    output logic              line_oe,
    output logic              busy,
    output done_t             done,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int CNT_W = $clog2(BRK_LOW + BRK_REC + CELL + RESP_WIN + 1);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int HALF  = CELL / 2;

    typedef enum logic [2:0] {
        S_IDLE, S_BRK_LO, S_BRK_HI, S_TX_LO, S_TX_HI, S_RX_WAIT, S_RX_CELL
    } st_e;

    typedef struct packed {
        st_e               st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] shreg;
        logic              line_prev;
        done_t             done;
    } eng_t;

    eng_t q, d;
    logic fall, last_bit;
    logic [CNT_W-1:0] low_last;

    always_comb begin
        d           = q;
        d.done      = '0;
        d.line_prev = line_s;
        fall        = q.line_prev & ~line_s;
        last_bit    = (q.idx == IDX_W'(DATA_W - 1));
        low_last    = q.shreg[0] ? CNT_W'(LOW1 - 1) : CNT_W'(LOW0 - 1);
        if (abort) begin
            d.st  = S_IDLE;
            d.cnt = '0;
        end else begin
            case (q.st)
                S_IDLE: if (start) begin
                    d.cnt = '0;
                    d.idx = '0;
                    case (op)
                        OP_TX:   begin d.st = S_TX_LO;   d.shreg = tx_byte; end
                        OP_RX:   begin d.st = S_RX_WAIT; d.shreg = '0;      end
                        default: d.st = S_BRK_LO;
                    endcase
                end
                S_BRK_LO: begin
                    if (q.cnt == CNT_W'(BRK_LOW - 1)) begin
                        d.st  = S_BRK_HI;
                        d.cnt = '0;
                    end else d.cnt = q.cnt + 1'b1;
                end
                S_BRK_HI: begin
                    if (q.cnt == CNT_W'(BRK_REC - 1)) begin
                        d.st       = S_IDLE;
                        d.done.brk = 1'b1;
                    end else d.cnt = q.cnt + 1'b1;
                end
                S_TX_LO: begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == low_last) d.st = S_TX_HI;
                end
                S_TX_HI: begin
                    if (q.cnt == CNT_W'(CELL - 1)) begin
                        if (last_bit) begin
                            d.st      = S_IDLE;
                            d.done.tx = 1'b1;
                        end else begin
                            d.st    = S_TX_LO;
                            d.idx   = q.idx + 1'b1;
                            d.shreg = q.shreg >> 1;
                            d.cnt   = '0;
                        end
                    end else d.cnt = q.cnt + 1'b1;
                end
                S_RX_WAIT: begin
                    if (fall) begin
                        d.st  = S_RX_CELL;
                        d.cnt = '0;
                    end else if (q.cnt == CNT_W'(RESP_WIN - 1)) begin
                        d.st          = S_IDLE;
                        d.done.silent = 1'b1;
                    end else d.cnt = q.cnt + 1'b1;
                end
                S_RX_CELL: begin
                    if (q.cnt == CNT_W'(HALF)) begin
                        d.shreg = {line_s, q.shreg[DATA_W-1:1]};
                        d.cnt   = '0;
                        if (last_bit) begin
                            d.st      = S_IDLE;
                            d.done.rx = 1'b1;
                        end else begin
                            d.st  = S_RX_WAIT;
                            d.idx = q.idx + 1'b1;
                        end
                    end else d.cnt = q.cnt + 1'b1;
                end
                default: d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.line_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign line_oe = (q.st == S_BRK_LO) || (q.st == S_TX_LO);
    assign busy    = (q.st != S_IDLE);
    assign done    = q.done;
    assign rx_byte = q.shreg;

    // R10: the register side only launches an operation into an idle engine
    a_r10_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (q.st == S_IDLE));
    // R3 R4 R5 R6: an operation ends with exactly one kind of completion
    a_r3_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done.tx, done.rx, done.brk, done.silent}));
    // R11: an abort releases the wire on the next cycle
    a_r11_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !line_oe);
endmodule

// File: rtl/swire_master.sv
module swire_master
    import swire_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int REV_MAJOR  = 1,
    parameter int REV_MINOR  = 2,
    parameter int BRK_LOW    = 40,
    parameter int BRK_REC    = 20,
    parameter int CELL       = 30,
    parameter int LOW1       = 6,
    parameter int LOW0       = 22,
    parameter int RESP_WIN   = 80,
    parameter int RST_CYCLES = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq,
    output logic              line_oe,
    input  logic              line_in
);
    localparam int RC_W = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        logic [7:0]      ctl;
        logic [2:0]      flags;
        logic [7:0]      txd;
        logic [7:0]      rxd;
        logic            idle_en;
        logic [RC_W-1:0] rst_cnt;
        logic [7:0]      rdata;
    } regs_t;

    regs_t q, d;

    logic  line_s, busy, start, wr, rd, wr_ctl, clr_flags, srst;
    op_e   op;
    done_t done;
    logic  [7:0] rx_byte;
    logic  [2:0] set_flags;

    swire_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(line_in), .q_out(line_s)
    );

    swire_engine #(
        .DATA_W(8), .BRK_LOW(BRK_LOW), .BRK_REC(BRK_REC), .CELL(CELL),
        .LOW1(LOW1), .LOW0(LOW0), .RESP_WIN(RESP_WIN)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .tx_byte(q.txd),
        .abort(srst), .line_s(line_s), .line_oe(line_oe), .busy(busy),
        .done(done), .rx_byte(rx_byte)
    );

    always_comb begin
        wr        = reg_sel & reg_we;
        rd        = reg_sel & ~reg_we;
        wr_ctl    = wr && (reg_addr == ADDR_W'(OFF_CTL));
        clr_flags = rd && (reg_addr == ADDR_W'(OFF_FLG));
        srst      = wr && (reg_addr == ADDR_W'(OFF_CFG)) && reg_wdata[CFG_SRST];
        start     = wr_ctl && reg_wdata[CB_GO] && !busy;
        op        = reg_wdata[CB_INIT] ? OP_BRK : (reg_wdata[CB_DIR] ? OP_RX : OP_TX);
        set_flags = {done.tx, done.rx, done.brk | done.silent};

        d = q;
        if (q.rst_cnt != '0) d.rst_cnt = q.rst_cnt - 1'b1;

        if (wr) begin
            case (int'(reg_addr))
                OFF_TXD: d.txd = reg_wdata;
                OFF_CTL: if (!busy) d.ctl = reg_wdata & CTL_MASK;
                OFF_CFG: d.idle_en = reg_wdata[CFG_IDLE];
                default: ;
            endcase
        end

        if (done.rx) d.rxd = rx_byte;
        if ((|set_flags) && q.ctl[CB_IE] && !wr_ctl) begin
            d.ctl[CB_GO]   = 1'b0;
            d.ctl[CB_INIT] = 1'b0;
        end
        d.flags = (clr_flags ? 3'b000 : q.flags) | set_flags;

        if (rd) begin
            case (int'(reg_addr))
                OFF_REV: d.rdata = {REV_MAJOR[3:0], REV_MINOR[3:0]};
                OFF_TXD: d.rdata = q.txd;
                OFF_RXD: d.rdata = q.rxd;
                OFF_CTL: d.rdata = q.ctl;
                OFF_FLG: d.rdata = {5'b0, q.flags};
                OFF_CFG: d.rdata = {7'b0, q.idle_en};
                OFF_STS: d.rdata = {7'b0, q.rst_cnt == '0};
                default: d.rdata = 8'h00;
            endcase
        end

        if (srst) begin
            d         = '0;
            d.rst_cnt = RC_W'(RST_CYCLES);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.rst_cnt <= RC_W'(RST_CYCLES);
        end else begin
            q <= d;
        end
    end

    assign reg_rdata = q.rdata;
    assign irq       = q.ctl[CB_IE] & (|q.flags);

    // R6: with interrupts on, completion drops go and initialise
    a_r6_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((|done) && q.ctl[CB_IE] && !reg_sel) |=> (!q.ctl[CB_GO] && !q.ctl[CB_INIT]));
    // R9: with interrupts off, go survives completion
    a_r9_go_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((|done) && !q.ctl[CB_IE] && q.ctl[CB_GO] && !reg_sel) |=> q.ctl[CB_GO]);
    // R7: a flag read with nothing new arriving leaves all flags clear
    a_r7_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flags && !(|done)) |=> (q.flags == 3'b000));
    // R11: soft reset drops reset-done and releases the wire
    a_r11_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (q.rst_cnt != '0 && !line_oe && q.ctl == 8'h00));
    // R8: interrupt never raised without the enable
    a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> q.ctl[CB_IE]);
endmodule

// File: tb/swire_master_bench.sv
`timescale 1ns/1ps
module swire_master_bench;
    localparam int BRK_LOW = 40, BRK_REC = 20, CELL = 30, LOW1 = 6, LOW0 = 22;
    localparam int RESP_WIN = 80, RST_CYCLES = 4;
    localparam logic [7:0] A_REV = 8'h00, A_TXD = 8'h04, A_RXD = 8'h08, A_CTL = 8'h0C,
                           A_FLG = 8'h10, A_CFG = 8'h14, A_STS = 8'h18;
    // vector: kind (0 write, 1 read, 2 break) and data byte
    localparam logic [9:0] VECS [0:7] = '{
        {2'd0, 8'hA5}, {2'd0, 8'h00}, {2'd1, 8'h3C}, {2'd0, 8'hFF},
        {2'd2, 8'h00}, {2'd1, 8'h81}, {2'd0, 8'h01}, {2'd1, 8'hFE}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_sel = 1'b0, reg_we = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic irq, line_oe, line_in, slave_pull = 1'b0;
    int checks = 0, fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;
    assign line_in = ~(line_oe | slave_pull);

    swire_master #(.ADDR_W(5), .REV_MAJOR(1), .REV_MINOR(2), .BRK_LOW(BRK_LOW),
        .BRK_REC(BRK_REC), .CELL(CELL), .LOW1(LOW1), .LOW0(LOW0),
        .RESP_WIN(RESP_WIN), .RST_CYCLES(RST_CYCLES), .SYNC_STAGES(2)) u_swire_master (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .line_oe(line_oe), .line_in(line_in));

    // wire monitor: measures every pull-down pulse of the master
    int lo_run = 0, mon_bits = 0, mon_brk = 0, mon_bad = 0;
    logic [7:0] mon_byte = '0;
    always @(posedge clk) begin
        if (line_oe) lo_run++;
        else if (lo_run > 0) begin
            if (lo_run == LOW1)         begin mon_byte = {1'b1, mon_byte[7:1]}; mon_bits++; end
            else if (lo_run == LOW0)    begin mon_byte = {1'b0, mon_byte[7:1]}; mon_bits++; end
            else if (lo_run == BRK_LOW) mon_brk++;
            else                        mon_bad++;
            lo_run = 0;
        end
    end

    task automatic mon_clear();
        mon_bits = 0; mon_brk = 0; mon_bad = 0; mon_byte = '0;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk); reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a[4:0]; reg_wdata = v;
        @(negedge clk); reg_sel = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk); reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a[4:0];
        @(negedge clk); reg_sel = 1'b0; v = reg_rdata;
    endtask

    task automatic slave_send(input logic [7:0] b);
        repeat (10) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            slave_pull = 1'b1;
            repeat (b[i] ? LOW1 : LOW0) @(negedge clk);
            slave_pull = 1'b0;
            repeat (CELL - (b[i] ? LOW1 : LOW0)) @(negedge clk);
        end
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, last_rx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // reset state
        rd(A_REV, v); chk("R1 revision", v, 8'h12);
        rd(A_CTL, v); chk("R1 ctrl reset", v, 8'h00);
        rd(A_FLG, v); chk("R1 flags reset", v, 8'h00);
        rd(A_STS, v); chk("R11 reset done after reset", v, 8'h01);
        rd(8'h1C, v); chk("R1 unused offset", v, 8'h00);
        chk("R8 irq reset", {7'b0, irq}, 8'h00);
        chk("R3 line released", {7'b0, line_oe}, 8'h00);

        // control bit layout, go left at 0
        wr(A_CTL, 8'hEF); rd(A_CTL, v); chk("R2 ctrl bits", v, 8'h67);
        wr(A_CTL, 8'h00);
        wr(A_CFG, 8'h01); rd(A_CFG, v); chk("R12 autoidle set", v, 8'h01);
        wr(A_CFG, 8'h00); rd(A_CFG, v); chk("R12 autoidle clear", v, 8'h00);

        // vector walk
        last_rx = 8'h00;
        foreach (VECS[k]) begin
            logic [1:0] kind = VECS[k][9:8];
            logic [7:0] dat  = VECS[k][7:0];
            mon_clear();
            if (kind == 2'd0) begin
                wr(A_TXD, dat); wr(A_CTL, 8'h70);
                repeat (8 * CELL + 10) @(negedge clk);
                chk("R3 byte on wire", mon_byte, dat);
                chk("R3 bit count", 8'(mon_bits + mon_bad), 8'd8);
                chk("R8 irq raised", {7'b0, irq}, 8'h01);
                rd(A_CTL, v); chk("R6 go cleared after write", v, 8'h60);
                rd(A_FLG, v); chk("R3 tx flag", v, 8'h04);
            end else if (kind == 2'd1) begin
                wr(A_CTL, 8'h72);
                slave_send(dat);
                repeat (10) @(negedge clk);
                rd(A_RXD, v); chk("R4 received byte", v, dat);
                chk("R4 master silent", 8'(mon_bits + mon_brk + mon_bad), 8'd0);
                chk("R8 irq raised", {7'b0, irq}, 8'h01);
                rd(A_CTL, v); chk("R4 go cleared after read", v, 8'h62);
                rd(A_FLG, v); chk("R4 rx flag", v, 8'h02);
                last_rx = dat;
            end else begin
                wr(A_CTL, 8'h74);
                repeat (BRK_LOW + BRK_REC + 10) @(negedge clk);
                chk("R6 one break pulse", 8'(mon_brk), 8'd1);
                rd(A_CTL, v); chk("R6 init and go cleared", v, 8'h60);
                rd(A_FLG, v); chk("R6 timeout flag", v, 8'h01);
            end
            rd(A_FLG, v); chk("R7 flags cleared by read", v, 8'h00);
            chk("R8 irq dropped", {7'b0, irq}, 8'h00);
        end

        // silent slave
        wr(A_CTL, 8'h72);
        repeat (RESP_WIN + 10) @(negedge clk);
        rd(A_FLG, v); chk("R5 timeout flag", v, 8'h01);
        rd(A_CTL, v); chk("R5 go cleared", v, 8'h62);
        rd(A_RXD, v); chk("R5 rx unchanged", v, last_rx);

        // interrupts disabled
        mon_clear();
        wr(A_TXD, 8'h96); wr(A_CTL, 8'h30);
        repeat (8 * CELL + 10) @(negedge clk);
        chk("R9 irq stays low", {7'b0, irq}, 8'h00);
        rd(A_CTL, v); chk("R9 go held", v, 8'h30);
        mon_clear();
        repeat (60) @(negedge clk);
        chk("R9 no restart", 8'(mon_bits + mon_brk + mon_bad), 8'd0);
        rd(A_FLG, v); chk("R9 tx flag still set", v, 8'h04);
        wr(A_CTL, 8'h60);

        // control write during an operation
        mon_clear();
        wr(A_TXD, 8'h3C); wr(A_CTL, 8'h70);
        repeat (20) @(negedge clk);
        wr(A_CTL, 8'h00);
        rd(A_CTL, v); chk("R10 ctrl write ignored", v, 8'h70);
        repeat (8 * CELL) @(negedge clk);
        chk("R10 byte intact", mon_byte, 8'h3C);
        rd(A_FLG, v); chk("R10 tx flag", v, 8'h04);

        // soft reset in mid transfer
        mon_clear();
        wr(A_CFG, 8'h01);
        wr(A_TXD, 8'h55); wr(A_CTL, 8'h70);
        repeat (50) @(negedge clk);
        wr(A_CFG, 8'h03);
        rd(A_STS, v); chk("R11 reset in progress", v, 8'h00);
        chk("R11 line released", {7'b0, line_oe}, 8'h00);
        repeat (10) @(negedge clk);
        rd(A_STS, v); chk("R11 reset done", v, 8'h01);
        rd(A_CTL, v); chk("R11 ctrl cleared", v, 8'h00);
        rd(A_CFG, v); chk("R11 config cleared", v, 8'h00);
        rd(A_TXD, v); chk("R11 tx data cleared", v, 8'h00);
        rd(A_RXD, v); chk("R11 rx data cleared", v, 8'h00);
        rd(A_FLG, v); chk("R11 no flag", v, 8'h00);
        repeat (8 * CELL) @(negedge clk);
        chk("R11 transfer aborted", 8'(mon_bits < 8), 8'd1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule